// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. In one pass it takes two byte operands, an operation code and a bit selector. The second operand can be a register value or an immediate that the caller has already placed on the port. The block returns a byte result and the status value that the operation produces. The status byte itself is held in a register inside the block. That register is written on a clock edge whenever `op_en` is high, and its stored carry, zero and T bits feed the next operation.

Each operation writes only its own group of status bits. The rest keep their previous values. So a caller can run increments or logic operations between the bytes of a multi-byte add and the carry survives. Subtract-with-carry and compare-with-carry only ever clear Z, so a chain of byte compares ends with Z set only when every byte matched.

Top module: `byte_alu_core`

## Requirements
- R1: Status bit positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0. Synchronous reset (rst_n low at a clock edge) clears the status to 0x00. With `op_en` low the status holds. Op codes: ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, CMPC=5, AND=6, OR=7, XOR=8, COM=9, NEG=10, INC=11, DEC=12, LSL=13, LSR=14, ROL=15, ROR=16, ASR=17, SWAP=18, BSET=19, BCLR=20, BST=21, BLD=22.
- R2: ADD and ADC give A+B (ADC adds C) and update H (carry out of bit 3), S, V (signed overflow), N, Z and C. I and T are unchanged.
- R3: SUB and SBC give A-B (SBC also subtracts C). NEG gives 0x00-A. All three update H (borrow into bit 4), S, V, N, Z and C.
- R4: For SBC and CMPC, Z becomes 0 if the difference is nonzero and otherwise keeps its previous value.
- R5: CMP and CMPC set the same flags as SUB and SBC, but `result` equals operand A.
- R6: AND, OR and XOR update Z and N, clear V, set S=N, and keep H and C.
- R7: COM gives 0xFF-A, sets C=1, clears V, and updates N, Z and S. H is unchanged.
- R8: INC and DEC update Z, N, V and S. INC sets V only for a result of 0x80, and DEC sets V only for a result of 0x7F. C and H are unchanged.
- R9: LSL, LSR, ROL, ROR and ASR move the bit shifted out into C. LSL and LSR shift in 0, ROL and ROR shift in the old C, and ASR keeps bit 7. V becomes N xor C, and Z, N and S are updated. H is unchanged.
- R10: SWAP exchanges the two nibbles of A and changes no status bit.
- R11: BST copies A[bit_sel] into T. BLD returns A with bit bit_sel replaced by T. Neither changes any other status bit.
- R12: BSET sets and BCLR clears status bit bit_sel, with no other status change. For both, `result` equals A.
- R13: Op codes 23 to 31 return A and leave the status unchanged.
- R14: Every operation that updates N or V writes S = N xor V, using the new N and V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_en | input | 1 | Commit the status from this operation at the next edge |
| op_code | input | 5 | Operation code (see R1) |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand or immediate |
| bit_sel | input | 3 | Bit index for BST, BLD, BSET and BCLR |
| result | output | 8 | Combinational result |
| flags_next | output | 8 | Status value the current operation would commit |
| status | output | 8 | Registered status byte |

## Verification
Some properties are checked by the assertions on every committed cycle:
- the status holds when no operation is issued;
- INC and DEC keep carry and half-carry;
- logic operations keep H and C and clear V;
- SWAP and undefined codes leave the status as it was;
- Z never rises through SBC or CMPC;
- S matches N xor V after any arithmetic, logic or shift.

The exact result and flag values can only be shown by the bench's vectors. These include overflow at the signed boundaries, half-carry and borrow across bit 3, NEG of 0x00 and 0x80, carry chaining through ADC, the sticky Z chain, and bit moves through T.

// File: rtl/byte_alu_pkg.sv
// byte_alu_pkg: shared operation codes, status bit positions and flag-group
// masks for the byte ALU. Assumes an 8-bit status byte.
package byte_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_CMPC = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18,
        OP_BSET = 5'd19,
        OP_BCLR = 5'd20,
        OP_BST  = 5'd21,
        OP_BLD  = 5'd22
    } alu_op_e;

    localparam int ST_W = 8;
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    // Flag groups written by each operation class.
    localparam logic [ST_W-1:0] GRP_ARITH = 8'b0011_1111; // H S V N Z C
    localparam logic [ST_W-1:0] GRP_LOGIC = 8'b0001_1110; // S V N Z
    localparam logic [ST_W-1:0] GRP_SHIFT = 8'b0001_1111; // S V N Z C
    localparam logic [ST_W-1:0] GRP_TBIT  = 8'b0100_0000; // T

    localparam logic [4:0] OP_LAST_DEFINED = 5'd22;

endpackage

// File: rtl/alu_addsub.sv
// alu_addsub: one shared adder for add, subtract, compare and negate.
// Subtraction is done as A + ~B + ~borrow. The carry and half-carry outs
// are inverted so that they read as borrows. Assumes W is even.
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    localparam int HB = W / 2;

    logic [W-1:0] b_eff;
    logic         ci;
    logic [W:0]   full;
    logic [HB:0]  low;

    // Adder with operand inversion for subtract; flags are taken from the internal carries.
    always_comb begin
        b_eff = sub ? ~b : b;
        ci    = sub ^ cin;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci};
        low   = {1'b0, a[HB-1:0]} + {1'b0, b_eff[HB-1:0]} + {{HB{1'b0}}, ci};
        sum   = full[W-1:0];
        c_out = full[W] ^ sub;
        h_out = low[HB] ^ sub;
        v_out = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_unary.sv
// alu_unary: logic, single-operand and bit-move operations. Produces the
// result, the carry it proposes and the overflow it proposes. Assumes that
// operations it does not handle are never selected by the top.
module alu_unary
    import byte_alu_pkg::*;
#(
    parameter int W     = 8,
    parameter int SEL_W = $clog2(W)
) (
    input  alu_op_e          op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             c_in,
    input  logic             t_in,
    output logic [W-1:0]     res,
    output logic             c_out,
    output logic             v_out
);
    localparam int HB = W / 2;
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    logic shift_cls;

    // Result, carry and overflow for each operation of this group.
    always_comb begin
        res       = a;
        c_out     = c_in;
        v_out     = 1'b0;
        shift_cls = 1'b0;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM: begin
                res   = ~a;
                c_out = 1'b1;
            end
            OP_INC: begin
                res   = a + {{(W-1){1'b0}}, 1'b1};
                v_out = (res == MIN_NEG);
            end
            OP_DEC: begin
                res   = a - {{(W-1){1'b0}}, 1'b1};
                v_out = (res == MAX_POS);
            end
            OP_LSL: begin
                res       = {a[W-2:0], 1'b0};
                c_out     = a[W-1];
                shift_cls = 1'b1;
            end
            OP_ROL: begin
                res       = {a[W-2:0], c_in};
                c_out     = a[W-1];
                shift_cls = 1'b1;
            end
            OP_LSR: begin
                res       = {1'b0, a[W-1:1]};
                c_out     = a[0];
                shift_cls = 1'b1;
            end
            OP_ROR: begin
                res       = {c_in, a[W-1:1]};
                c_out     = a[0];
                shift_cls = 1'b1;
            end
            OP_ASR: begin
                res       = {a[W-1], a[W-1:1]};
                c_out     = a[0];
                shift_cls = 1'b1;
            end
            OP_SWAP: res = {a[HB-1:0], a[W-1:HB]};
            OP_BLD: begin
                res          = a;
                res[bit_sel] = t_in;
            end
            default: res = a;
        endcase
        if (shift_cls) begin
            v_out = res[W-1] ^ c_out;
        end
    end
endmodule

// File: rtl/alu_status_reg.sv
// alu_status_reg: the status byte register. It loads on write enable,
// clears on synchronous active-low reset, and otherwise holds.
module alu_status_reg
    import byte_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [ST_W-1:0] d,
    output logic [ST_W-1:0] q
);
    // Status storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (q == '0)); // R1
    AST_IDLE_HOLDS:   assert property (@(posedge clk) disable iff (!rst_n)
                                       !we |=> $stable(q)); // R1
endmodule

// File: rtl/byte_alu_core.sv
// byte_alu_core: byte ALU with a registered status byte. It selects the
// operation, merges each operation's flag group into the stored status,
// and commits the merged value when op_en is high. Operand B carries either
// a register value or an immediate; the caller decides which.
module byte_alu_core
    import byte_alu_pkg::*;
#(
    parameter int W     = 8,
    parameter int SEL_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_en,
    input  logic [4:0]       op_code,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [SEL_W-1:0] bit_sel,
    output logic [W-1:0]     result,
    output logic [ST_W-1:0]  flags_next,
    output logic [ST_W-1:0]  status
);
    alu_op_e op;
    assign op = alu_op_e'(op_code);

    logic [W-1:0] as_a, as_b, as_sum;
    logic         as_cin, as_sub, as_c, as_h, as_v;
    logic [W-1:0] un_res;
    logic         un_c, un_v;
    logic [ST_W-1:0] nf, grp;
    logic         write_s;

    // Operand steering for the shared adder.
    always_comb begin
        as_a   = opnd_a;
        as_b   = opnd_b;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC:  as_cin = status[FL_C];
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC, OP_CMPC: begin
                as_sub = 1'b1;
                as_cin = status[FL_C];
            end
            OP_NEG: begin
                as_sub = 1'b1;
                as_a   = '0;
                as_b   = opnd_a;
            end
            default: ;
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .c_out(as_c), .h_out(as_h), .v_out(as_v)
    );

    alu_unary #(.W(W), .SEL_W(SEL_W)) u_unary (
        .op(op), .a(opnd_a), .b(opnd_b), .bit_sel(bit_sel),
        .c_in(status[FL_C]), .t_in(status[FL_T]),
        .res(un_res), .c_out(un_c), .v_out(un_v)
    );

    // Result selection, proposed flag values and the flag group to write.
    always_comb begin
        result  = opnd_a;
        nf      = status;
        grp     = '0;
        write_s = 1'b1;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                result   = as_sum;
                grp      = GRP_ARITH;
                nf[FL_H] = as_h;
                nf[FL_V] = as_v;
                nf[FL_N] = as_sum[W-1];
                nf[FL_C] = as_c;
                nf[FL_Z] = (as_sum == '0);
                if (op == OP_SBC) nf[FL_Z] = (as_sum == '0) & status[FL_Z];
            end
            OP_CMP, OP_CMPC: begin
                grp      = GRP_ARITH;
                nf[FL_H] = as_h;
                nf[FL_V] = as_v;
                nf[FL_N] = as_sum[W-1];
                nf[FL_C] = as_c;
                nf[FL_Z] = (op == OP_CMPC) ? ((as_sum == '0) & status[FL_Z])
                                           : (as_sum == '0);
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
                result   = un_res;
                grp      = GRP_LOGIC;
                nf[FL_V] = un_v;
                nf[FL_N] = un_res[W-1];
                nf[FL_Z] = (un_res == '0);
            end
            OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                result   = un_res;
                grp      = GRP_SHIFT;
                nf[FL_V] = un_v;
                nf[FL_N] = un_res[W-1];
                nf[FL_Z] = (un_res == '0);
                nf[FL_C] = un_c;
            end
            OP_SWAP, OP_BLD: begin
                result  = un_res;
                write_s = 1'b0;
            end
            OP_BST: begin
                grp      = GRP_TBIT;
                nf[FL_T] = opnd_a[bit_sel];
                write_s  = 1'b0;
            end
            OP_BSET, OP_BCLR: begin
                grp          = '0;
                grp[bit_sel] = 1'b1;
                nf           = {ST_W{op == OP_BSET}};
                write_s      = 1'b0;
            end
            default: write_s = 1'b0;
        endcase
        if (write_s) begin
            nf[FL_S] = nf[FL_N] ^ nf[FL_V];
        end
        flags_next = (status & ~grp) | (nf & grp);
    end

    alu_status_reg u_status (
        .clk(clk), .rst_n(rst_n), .we(op_en), .d(flags_next), .q(status)
    );

    AST_SBC_Z_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (op_code == 5'd3 || op_code == 5'd5) && !status[FL_Z])
        |=> !status[FL_Z]); // R4
    AST_LOGIC_KEEP_HC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code >= 5'd6 && op_code <= 5'd8)
        |=> (status[FL_H] == $past(status[FL_H]) && status[FL_C] == $past(status[FL_C])
             && !status[FL_V])); // R6
    AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (op_code == 5'd11 || op_code == 5'd12))
        |=> (status[FL_C] == $past(status[FL_C]) && status[FL_H] == $past(status[FL_H]))); // R8
    AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code == 5'd18) |=> $stable(status)); // R10
    AST_UNDEF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code > OP_LAST_DEFINED) |=> $stable(status)); // R13
    AST_S_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code <= 5'd17)
        |=> (status[FL_S] == (status[FL_N] ^ status[FL_V]))); // R14
endmodule

// File: tb/sim_byte_alu_core.sv
module sim_byte_alu_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_en = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] result, flags_next, status;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    byte_alu_core u0 (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .bit_sel(bit_sel),
        .result(result), .flags_next(flags_next), .status(status)
    );

    // {req, op, a, b, bit, status_in, result_exp, status_exp}
    localparam int NV = 36;
    localparam logic [51:0] VEC [NV] = '{
        {4'd2,  5'd0,  8'h0F, 8'h01, 3'd0, 8'h00, 8'h10, 8'h20}, // R2 half carry
        {4'd14, 5'd0,  8'h7F, 8'h01, 3'd0, 8'h00, 8'h80, 8'h2C}, // R2 R14 overflow, S=0
        {4'd2,  5'd0,  8'h80, 8'h80, 3'd0, 8'h00, 8'h00, 8'h1B}, // R2 carry zero overflow
        {4'd2,  5'd1,  8'hFF, 8'h00, 3'd0, 8'h01, 8'h00, 8'h23}, // R2 carry in
        {4'd2,  5'd1,  8'h0E, 8'h01, 3'd0, 8'h01, 8'h10, 8'h20}, // R2
        {4'd3,  5'd2,  8'h10, 8'h01, 3'd0, 8'h00, 8'h0F, 8'h20}, // R3 half borrow
        {4'd3,  5'd2,  8'h00, 8'h01, 3'd0, 8'h00, 8'hFF, 8'h35}, // R3 borrow
        {4'd3,  5'd2,  8'h80, 8'h01, 3'd0, 8'h00, 8'h7F, 8'h38}, // R3 overflow
        {4'd4,  5'd3,  8'h05, 8'h05, 3'd0, 8'h00, 8'h00, 8'h00}, // R4 zero kept clear
        {4'd4,  5'd3,  8'h05, 8'h05, 3'd0, 8'h02, 8'h00, 8'h02}, // R4 zero kept set
        {4'd4,  5'd3,  8'h05, 8'h04, 3'd0, 8'h03, 8'h00, 8'h02}, // R4 with carry
        {4'd5,  5'd5,  8'h03, 8'h05, 3'd0, 8'h02, 8'h03, 8'h35}, // R5 R4 nonzero clears Z
        {4'd5,  5'd4,  8'h42, 8'h42, 3'd0, 8'h00, 8'h42, 8'h02}, // R5
        {4'd6,  5'd6,  8'hF0, 8'h0F, 3'd0, 8'h29, 8'h00, 8'h23}, // R6 keeps H C, V cleared
        {4'd6,  5'd7,  8'h80, 8'h01, 3'd0, 8'h00, 8'h81, 8'h14}, // R6
        {4'd6,  5'd8,  8'hAA, 8'hFF, 3'd0, 8'h00, 8'h55, 8'h00}, // R6
        {4'd7,  5'd9,  8'h00, 8'h00, 3'd0, 8'h00, 8'hFF, 8'h15}, // R7
        {4'd3,  5'd10, 8'h80, 8'h00, 3'd0, 8'h00, 8'h80, 8'h0D}, // R3 neg of 0x80
        {4'd3,  5'd10, 8'h01, 8'h00, 3'd0, 8'h00, 8'hFF, 8'h35}, // R3
        {4'd3,  5'd10, 8'h00, 8'h00, 3'd0, 8'h00, 8'h00, 8'h02}, // R3 neg of zero
        {4'd8,  5'd11, 8'h7F, 8'h00, 3'd0, 8'h01, 8'h80, 8'h0D}, // R8 keeps C
        {4'd8,  5'd11, 8'hFF, 8'h00, 3'd0, 8'h00, 8'h00, 8'h02}, // R8 wrap, no C
        {4'd8,  5'd12, 8'h80, 8'h00, 3'd0, 8'h20, 8'h7F, 8'h38}, // R8 keeps H
        {4'd9,  5'd13, 8'h81, 8'h00, 3'd0, 8'h00, 8'h02, 8'h19}, // R9
        {4'd9,  5'd14, 8'h01, 8'h00, 3'd0, 8'h00, 8'h00, 8'h1B}, // R9
        {4'd9,  5'd15, 8'h80, 8'h00, 3'd0, 8'h01, 8'h01, 8'h19}, // R9
        {4'd9,  5'd16, 8'h02, 8'h00, 3'd0, 8'h01, 8'h81, 8'h0C}, // R9
        {4'd9,  5'd17, 8'h81, 8'h00, 3'd0, 8'h00, 8'hC0, 8'h15}, // R9
        {4'd10, 5'd18, 8'h3C, 8'h00, 3'd0, 8'hA5, 8'hC3, 8'hA5}, // R10
        {4'd11, 5'd21, 8'h08, 8'h00, 3'd3, 8'h00, 8'h08, 8'h40}, // R11 store 1
        {4'd11, 5'd21, 8'hF7, 8'h00, 3'd3, 8'hFF, 8'hF7, 8'hBF}, // R11 store 0
        {4'd11, 5'd22, 8'h00, 8'h00, 3'd7, 8'h40, 8'h80, 8'h40}, // R11 load 1
        {4'd11, 5'd22, 8'hFF, 8'h00, 3'd0, 8'h00, 8'hFE, 8'h00}, // R11 load 0
        {4'd12, 5'd19, 8'h12, 8'h00, 3'd7, 8'h00, 8'h12, 8'h80}, // R12
        {4'd12, 5'd20, 8'h34, 8'h00, 3'd0, 8'hFF, 8'h34, 8'hFE}, // R12
        {4'd13, 5'd31, 8'h5A, 8'h00, 3'd0, 8'h6B, 8'h5A, 8'h6B}  // R13
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] c, input logic [7:0] a, input logic [7:0] b,
                         input logic [2:0] s, input logic en);
        @(negedge clk);
        op_code = c; opnd_a = a; opnd_b = b; bit_sel = s; op_en = en;
    endtask

    task automatic load_status(input logic [7:0] v);
        for (int k = 0; k < 8; k++) begin
            issue(v[k] ? 5'd19 : 5'd20, 8'h00, 8'h00, 3'(k), 1'b1);
        end
        @(negedge clk);
        op_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", status, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [51:0] v;
            string tag;
            v = VEC[i];
            load_status(v[23:16]);
            issue(v[47:43], v[42:35], v[34:27], v[26:24], 1'b1);
            #1;
            tag = $sformatf("R%0d result vec%0d", v[51:48], i);
            check(tag, result, v[15:8]);
            @(posedge clk);
            #1;
            op_en = 1'b0;
            tag = $sformatf("R%0d status vec%0d", v[51:48], i);
            check(tag, status, v[7:0]);
        end

        // R1: op_en low must not commit
        load_status(8'h00);
        issue(5'd0, 8'h80, 8'h80, 3'd0, 1'b0);
        @(posedge clk); #1;
        check("R1 hold result", result, 8'h00);
        check("R1 hold status", status, 8'h00);

        // R2 multi-byte add: 0x01FF + 0x0001 = 0x0200 via ADD then ADC
        issue(5'd0, 8'hFF, 8'h01, 3'd0, 1'b1);
        @(posedge clk); #1;
        check("R2 low byte", result, 8'h00);
        issue(5'd1, 8'h01, 8'h00, 3'd0, 1'b1);
        #1;
        check("R2 high byte", result, 8'h02);

        // R1: reset mid-run clears status
        load_status(8'hFF);
        check("R1 preload", status, 8'hFF);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 reset clears", status, 8'h00);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule